// File: doc/BRIEF.md
# Byte/Word Host Data-Buffer Portal

This block sits between a microprocessor bus and an internal 16-bit data-buffer FIFO. It offers the host a single portal register. The register is aliased across a small address window, and the host bus can run 8 or 16 bits wide. A direction input selects how the portal behaves:

- **Write port:** the portal fills the buffer. The block collects the two bytes of a byte-mode transfer into one word and hands each finished word to the buffer through a valid/ready push interface.
- **Read port:** the portal drains the buffer. The block prefetches one word into a holding register through a valid/ready pop interface. It keeps that word steady until the host has taken it completely.

In byte mode the high byte is the commit point. A high-byte write pushes the word. A high-byte read releases the held word so the next one can load. A readiness output tells the host whether the portal can accept a write or has read data waiting. Two sticky flags record writes that were dropped and reads made while the portal was empty. Any change of the direction input discards half-built or prefetched data.

Top module: `hbuf_portal`

## Requirements
- R1: A host access counts only when `host_cs` is high and the address lies in the window. The window is 0x40–0x5F in byte mode (`bus_wide`=0) and 0x20–0x2F in word mode (`bus_wide`=1). Every address inside the window reaches the same register. Accesses outside the window have no effect, and their read data is 0.
- R2: In byte mode, address bit 0 = 0 selects the low byte and bit 0 = 1 selects the high byte. The byte travels on bits 7:0 of `host_wdata`/`host_rdata`. Bits 15:8 of read data are 0.
- R3: In byte-mode writes, a low-byte write only updates a holding byte and produces no push. A high-byte write raises `push_valid` in the same cycle, with `push_data` = {written byte, held low byte}.
- R4: In word mode, each write raises `push_valid` in that cycle with `push_data` = `host_wdata`.
- R5: On the read port, while the holding register is empty, `pop_ready` is high. A word offered with `pop_valid` is captured at that edge and is held from the next cycle.
- R6: In byte-mode reads, reading the low byte does not release the held word. Reading the high byte releases it, and the next pending word loads one cycle later.
- R7: In word mode, a read returns the full held word and releases it.
- R8: On the read port (`dir_wr`=0), writes never push and never change state. On the write port (`dir_wr`=1), reads return 0 and `pop_ready` stays low.
- R9: A high-byte or word write made while `push_ready` is low is dropped, and `ovf_flag` becomes 1 and stays 1 until reset.
- R10: A read made while the holding register is empty returns the last held value (0 after reset or flush). `unf_flag` becomes 1 and stays 1 until reset.
- R11: In the first cycle after `dir_wr` changes, host accesses and pops are ignored. The held low byte and the read holding register are cleared and emptied.
- R12: `buf_ready` equals `push_ready` on the write port. On the read port, `buf_ready` is high exactly when a word is held.
- R13: After reset, both flags are 0, nothing is held, and read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wide | input | 1 | 1 = 16-bit host bus, 0 = 8-bit host bus |
| dir_wr | input | 1 | 1 = write port (fills buffer), 0 = read port (drains buffer) |
| host_cs | input | 1 | Host chip select |
| host_we | input | 1 | Host write strobe, one cycle per access |
| host_re | input | 1 | Host read strobe, one cycle per access |
| host_addr | input | 7 | Host address (byte or word units per `bus_wide`) |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, valid in the strobe cycle |
| buf_ready | output | 1 | Portal can take a write or holds read data |
| ovf_flag | output | 1 | Sticky dropped-write flag |
| unf_flag | output | 1 | Sticky empty-read flag |
| push_valid | output | 1 | Word offered to the buffer |
| push_data | output | 16 | Word being pushed |
| push_ready | input | 1 | Buffer can accept a word |
| pop_valid | input | 1 | Buffer has a word available |
| pop_data | input | 16 | Word at the buffer head |
| pop_ready | output | 1 | Portal takes the head word this cycle |

## Verification
The interesting collision is on the read side. A host read can land on an empty holding register in the very cycle that the buffer first offers a word. The read must then return the stale value and set the underflow flag, while the offered word is still captured for the next access. The bench provokes this by making a word appear on `pop_valid` in the same cycle as a read strobe once the source has run dry. It also provokes it at random in a mixed phase. A behavioural model judges the result by predicting read data, flags, `pop_ready` and `buf_ready` for that cycle and for the one after.

// File: rtl/hbp_pkg.sv
package hbp_pkg;

    // Direction of the portal.
    typedef enum logic {
        PORT_READ  = 1'b0,
        PORT_WRITE = 1'b1
    } hbp_dir_e;

    // One decoded host access.
    typedef struct packed {
        logic rd;   // read strobe hit the window
        logic wr;   // write strobe hit the window
        logic lo;   // low byte lane addressed
        logic hi;   // high byte lane addressed (commit lane)
    } hbp_acc_t;

    // True when addr falls in the aligned block of 2**span_lg starting at base.
    function automatic logic in_window(input logic [15:0] addr,
                                       input logic [15:0] base,
                                       input int unsigned span_lg);
        return (addr >> span_lg) == (base >> span_lg);
    endfunction

endpackage

// File: rtl/hbp_decode.sv
module hbp_decode
    import hbp_pkg::*;
#(
    parameter int unsigned ADDR_W       = 7,
    parameter int unsigned BYTE_BASE    = 'h40,
    parameter int unsigned BYTE_SPAN_LG = 5,
    parameter int unsigned WORD_BASE    = 'h20,
    parameter int unsigned WORD_SPAN_LG = 4
) (
    input  logic              host_cs,
    input  logic              host_we,
    input  logic              host_re,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              bus_wide,
    output hbp_acc_t          acc
);
    localparam logic [15:0] BYTE_BASE_V = 16'(BYTE_BASE);
    localparam logic [15:0] WORD_BASE_V = 16'(WORD_BASE);

    logic hit;

    always_comb begin
        if (bus_wide)
            hit = host_cs & in_window(16'(host_addr), WORD_BASE_V, WORD_SPAN_LG);
        else
            hit = host_cs & in_window(16'(host_addr), BYTE_BASE_V, BYTE_SPAN_LG);

        acc.rd = hit & host_re;
        acc.wr = hit & host_we;
        acc.lo = bus_wide | ~host_addr[0];
        acc.hi = bus_wide |  host_addr[0];
    end
endmodule

// File: rtl/hbp_wr_path.sv
module hbp_wr_path
    import hbp_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              en,
    input  logic              bus_wide,
    input  hbp_acc_t          acc,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              push_ready,
    output logic              push_valid,
    output logic [DATA_W-1:0] push_data,
    output logic              ovf_set
);
    localparam int unsigned BYTE_W = DATA_W / 2;

    logic [BYTE_W-1:0] lo_hold;

    // Low-byte holding register: only a narrow low-lane write loads it.
    always_ff @(posedge clk) begin
        if (rst || flush)
            lo_hold <= '0;
        else if (en && acc.wr && acc.lo && !bus_wide)
            lo_hold <= host_wdata[BYTE_W-1:0];
    end

    // A high-lane (or full-word) write is the commit point.
    always_comb begin
        push_valid = en & acc.wr & acc.hi;
        push_data  = bus_wide ? host_wdata
                              : {host_wdata[BYTE_W-1:0], lo_hold};
        ovf_set    = push_valid & ~push_ready;
    end
endmodule

// File: rtl/hbp_rd_path.sv
module hbp_rd_path
    import hbp_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              en,
    input  logic              bus_wide,
    input  hbp_acc_t          acc,
    input  logic              pop_valid,
    input  logic [DATA_W-1:0] pop_data,
    output logic              pop_ready,
    output logic [DATA_W-1:0] rdata,
    output logic              held,
    output logic              unf_set
);
    localparam int unsigned BYTE_W = DATA_W / 2;

    logic [DATA_W-1:0] rd_hold;
    logic              rd_full;
    logic              release_w;

    always_comb begin
        pop_ready = en & ~rd_full;
        release_w = en & acc.rd & acc.hi & rd_full;
        unf_set   = en & acc.rd & ~rd_full;
        held      = rd_full;

        rdata = '0;
        if (en && acc.rd) begin
            if (bus_wide)
                rdata = rd_hold;
            else if (acc.hi)
                rdata = {{BYTE_W{1'b0}}, rd_hold[DATA_W-1:BYTE_W]};
            else
                rdata = {{BYTE_W{1'b0}}, rd_hold[BYTE_W-1:0]};
        end
    end

    // Prefetch and release never coincide: one needs the register empty,
    // the other needs it full.
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_hold <= '0;
            rd_full <= 1'b0;
        end else if (pop_ready && pop_valid) begin
            rd_hold <= pop_data;
            rd_full <= 1'b1;
        end else if (release_w) begin
            rd_full <= 1'b0;
        end
    end
endmodule

// File: rtl/hbuf_portal.sv
module hbuf_portal
    import hbp_pkg::*;
#(
    parameter int unsigned ADDR_W       = 7,
    parameter int unsigned DATA_W       = 16,
    parameter int unsigned BYTE_BASE    = 'h40,
    parameter int unsigned BYTE_SPAN_LG = 5,
    parameter int unsigned WORD_BASE    = 'h20,
    parameter int unsigned WORD_SPAN_LG = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wide,
    input  logic              dir_wr,
    input  logic              host_cs,
    input  logic              host_we,
    input  logic              host_re,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              buf_ready,
    output logic              ovf_flag,
    output logic              unf_flag,
    output logic              push_valid,
    output logic [DATA_W-1:0] push_data,
    input  logic              push_ready,
    input  logic              pop_valid,
    input  logic [DATA_W-1:0] pop_data,
    output logic              pop_ready
);
    hbp_dir_e dir_now, dir_q;
    hbp_acc_t acc;
    logic     dir_chg, wr_en, rd_en, held, ovf_set, unf_set;

    assign dir_now = hbp_dir_e'(dir_wr);

    always_ff @(posedge clk) begin
        if (rst) dir_q <= PORT_READ;
        else     dir_q <= dir_now;
    end

    always_comb begin
        dir_chg = (dir_now != dir_q);
        wr_en   = (dir_now == PORT_WRITE) & ~dir_chg;
        rd_en   = (dir_now == PORT_READ)  & ~dir_chg;
    end

    hbp_decode #(
        .ADDR_W(ADDR_W), .BYTE_BASE(BYTE_BASE), .BYTE_SPAN_LG(BYTE_SPAN_LG),
        .WORD_BASE(WORD_BASE), .WORD_SPAN_LG(WORD_SPAN_LG)
    ) u_dec (
        .host_cs(host_cs), .host_we(host_we), .host_re(host_re),
        .host_addr(host_addr), .bus_wide(bus_wide), .acc(acc)
    );

    hbp_wr_path #(.DATA_W(DATA_W)) u_wr (
        .clk(clk), .rst(rst), .flush(dir_chg), .en(wr_en),
        .bus_wide(bus_wide), .acc(acc), .host_wdata(host_wdata),
        .push_ready(push_ready), .push_valid(push_valid),
        .push_data(push_data), .ovf_set(ovf_set)
    );

    hbp_rd_path #(.DATA_W(DATA_W)) u_rd (
        .clk(clk), .rst(rst), .flush(dir_chg), .en(rd_en),
        .bus_wide(bus_wide), .acc(acc), .pop_valid(pop_valid),
        .pop_data(pop_data), .pop_ready(pop_ready), .rdata(host_rdata),
        .held(held), .unf_set(unf_set)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_flag <= 1'b0;
            unf_flag <= 1'b0;
        end else begin
            if (ovf_set) ovf_flag <= 1'b1;
            if (unf_set) unf_flag <= 1'b1;
        end
    end

    assign buf_ready = (dir_now == PORT_WRITE) ? push_ready : held;
endmodule

// File: rtl/hbuf_portal_chk.sv
module hbuf_portal_chk #(
    parameter int unsigned ADDR_W = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wide,
    input logic              dir_wr,
    input logic              host_cs,
    input logic              host_we,
    input logic [ADDR_W-1:0] host_addr,
    input logic              push_valid,
    input logic              push_ready,
    input logic              pop_valid,
    input logic              pop_ready,
    input logic              buf_ready,
    input logic              ovf_flag,
    input logic              unf_flag
);
    AST_PUSH_WR_ONLY: assert property (@(posedge clk) disable iff (rst)
        push_valid |-> dir_wr); // R8
    AST_POP_RD_ONLY: assert property (@(posedge clk) disable iff (rst)
        pop_ready |-> !dir_wr); // R8
    AST_LOW_NO_PUSH: assert property (@(posedge clk) disable iff (rst)
        (host_cs && host_we && !bus_wide && !host_addr[0]) |-> !push_valid); // R3
    AST_BELOW_WIN_NO_PUSH: assert property (@(posedge clk) disable iff (rst)
        (!bus_wide && host_addr < ADDR_W'(7'h40)) |-> !push_valid); // R1
    AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
        (push_valid && !push_ready) |=> ovf_flag); // R9
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf_flag |=> ovf_flag); // R9
    AST_UNF_STICKY: assert property (@(posedge clk) disable iff (rst)
        unf_flag |=> unf_flag); // R10
    AST_PREFETCH_HELD: assert property (@(posedge clk) disable iff (rst)
        (pop_valid && pop_ready) |=> (buf_ready || dir_wr)); // R5
    AST_WR_READY: assert property (@(posedge clk) disable iff (rst)
        dir_wr |-> (buf_ready == push_ready)); // R12
endmodule

bind hbuf_portal hbuf_portal_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/hbuf_portal_tb_top.sv
`timescale 1ns/1ps
module hbuf_portal_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wide, dir_wr, host_cs, host_we, host_re;
    logic [6:0]  host_addr;
    logic [15:0] host_wdata, host_rdata, push_data, pop_data;
    logic        buf_ready, ovf_flag, unf_flag, push_valid, push_ready;
    logic        pop_valid, pop_ready;

    always #2.5 clk = ~clk;

    hbuf_portal dut_i (.*);

    int n_vec = 0, n_err = 0, cyc = 0;
    bit done = 0;
    string cur_req = "R13";

    // Reference model state
    logic [15:0] src_q[$];
    logic [7:0]  m_lo;
    logic [15:0] m_hold;
    bit m_full, m_ovf, m_unf, m_dirq, src_en;

    task automatic chk(string what, logic [15:0] act, logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_err++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    // One cycle: drive at negedge, compare, update the model at posedge.
    task automatic step(bit cs, bit we, bit re, logic [6:0] a, logic [15:0] wd);
        bit hit, chg, en_w, en_r, is_hi, is_lo, e_pv, e_prdy, take;
        logic [15:0] e_pd, e_rd;
        host_cs = cs; host_we = we; host_re = re; host_addr = a; host_wdata = wd;
        pop_valid = src_en && src_q.size() > 0;
        pop_data  = (src_q.size() > 0) ? src_q[0] : 16'h0;
        #1;
        hit   = cs && (bus_wide ? (a >= 7'h20 && a <= 7'h2F) : (a >= 7'h40 && a <= 7'h5F));
        chg   = (dir_wr != m_dirq);
        en_w  = dir_wr && !chg;
        en_r  = !dir_wr && !chg;
        is_hi = bus_wide || (a % 2 == 1);
        is_lo = bus_wide || (a % 2 == 0);
        e_pv  = en_w && hit && we && is_hi;
        e_pd  = bus_wide ? wd : {wd[7:0], m_lo};
        e_prdy = en_r && !m_full;
        e_rd  = 16'h0;
        if (en_r && hit && re)
            e_rd = bus_wide ? m_hold : (is_hi ? {8'h0, m_hold[15:8]} : {8'h0, m_hold[7:0]});
        chk("push_valid", 16'(push_valid), 16'(e_pv));
        if (e_pv) chk("push_data", push_data, e_pd);
        chk("pop_ready", 16'(pop_ready), 16'(e_prdy));
        chk("host_rdata", host_rdata, e_rd);
        chk("buf_ready", 16'(buf_ready), 16'(dir_wr ? push_ready : m_full));
        chk("ovf_flag", 16'(ovf_flag), 16'(m_ovf));
        chk("unf_flag", 16'(unf_flag), 16'(m_unf));
        take = e_prdy && pop_valid;
        @(posedge clk);
        if (chg) begin
            m_lo = 8'h0; m_full = 0; m_hold = 16'h0;
        end else begin
            if (en_w && hit && we && is_lo && !bus_wide) m_lo = wd[7:0];
            if (e_pv && !push_ready) m_ovf = 1;
            if (en_r) begin
                if (hit && re && !m_full) m_unf = 1;
                else if (hit && re && is_hi) m_full = 0;
                if (take) begin
                    m_hold = src_q.pop_front();
                    m_full = 1;
                end
            end
        end
        m_dirq = dir_wr;
        @(negedge clk);
    endtask

    task automatic wr(logic [6:0] a, logic [15:0] d); step(1, 1, 0, a, d); endtask
    task automatic rd(logic [6:0] a);                 step(1, 0, 1, a, 16'h0); endtask
    task automatic idle();                            step(0, 0, 0, 7'h0, 16'h0); endtask

    initial begin
        rst = 1; bus_wide = 0; dir_wr = 0; host_cs = 0; host_we = 0; host_re = 0;
        host_addr = 0; host_wdata = 0; push_ready = 1; pop_valid = 0; pop_data = 0;
        src_en = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        m_lo = 0; m_hold = 0; m_full = 0; m_ovf = 0; m_unf = 0; m_dirq = 0;

        cur_req = "R13"; idle(); rd(7'h40);  // reset state (this read also sets unf)
        rst = 1; @(negedge clk); rst = 0; m_unf = 0;

        // Write port, byte mode
        dir_wr = 1; cur_req = "R11"; idle();
        cur_req = "R3"; wr(7'h40, 16'h0034); wr(7'h41, 16'h0012);
        cur_req = "R1"; wr(7'h5E, 16'h00CD); wr(7'h43, 16'h00AB);
        wr(7'h3F, 16'h0077); wr(7'h60, 16'h0077); wr(7'h5F, 16'h0099);
        cur_req = "R2"; wr(7'h42, 16'hFF11); wr(7'h45, 16'hEE22);
        cur_req = "R8"; rd(7'h40); src_q.push_back(16'hA5A5); src_en = 1; rd(7'h41);
        src_q.delete(); src_en = 0;
        // Word mode writes
        bus_wide = 1; cur_req = "R4"; wr(7'h20, 16'hBEEF); wr(7'h2F, 16'h1357);
        cur_req = "R1"; wr(7'h30, 16'h2468); wr(7'h40, 16'h2468);
        // Overflow and ready tracking
        cur_req = "R12"; push_ready = 0; idle();
        cur_req = "R9"; wr(7'h21, 16'hDEAD); push_ready = 1; wr(7'h22, 16'h4321);
        // Flush of the low byte across a direction change
        bus_wide = 0; cur_req = "R11"; wr(7'h40, 16'h0055);
        dir_wr = 0; idle(); dir_wr = 1; wr(7'h40, 16'h0066); wr(7'h41, 16'h0066);
        // Read port
        dir_wr = 0; cur_req = "R5";
        src_q = '{16'h1111, 16'h2222, 16'h3333, 16'h4444};
        src_en = 1; idle(); idle();
        cur_req = "R6"; rd(7'h40); rd(7'h40); rd(7'h41); idle(); rd(7'h50);
        cur_req = "R8"; wr(7'h40, 16'h00FF); wr(7'h41, 16'h00EE); rd(7'h40);
        cur_req = "R6"; rd(7'h5F); idle();
        bus_wide = 1; cur_req = "R7"; rd(7'h20); idle(); rd(7'h2A); idle(); idle();
        cur_req = "R10"; rd(7'h20); rd(7'h21);
        // Empty read in the same cycle a word arrives
        src_q.push_back(16'h5A5A); rd(7'h24); rd(7'h24); idle();
        cur_req = "R11"; src_q.push_back(16'h6B6B); idle(); dir_wr = 1; idle();
        dir_wr = 0; idle(); idle(); rd(7'h25);

        // Mixed random phase
        cur_req = "R1";
        for (int i = 0; i < 600; i++) begin
            if (i % 50 == 0) dir_wr = $urandom_range(0, 1);
            if (i % 70 == 0) bus_wide = $urandom_range(0, 1);
            push_ready = ($urandom_range(0, 3) != 0);
            src_en = ($urandom_range(0, 3) != 0);
            if (src_q.size() < 3) src_q.push_back(16'($urandom));
            step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), 7'($urandom_range(16'h1C, 16'h63)),
                 16'($urandom));
        end

        done = 1;
        summary();
        $finish;
    end
endmodule